// File: doc/BRIEF.md
# LDPC Decoder Iteration Controller

This block sequences a partly parallel LDPC decoder in which each processing element serves `L` nodes over time. A start pulse begins a frame. The controller first runs an initialization pass of `L` cycles, which copies channel values into the message memories. It then runs decoding iterations. Each iteration has a check-node phase of `L` cycles followed by a variable-node phase of `L` cycles. Every memory bank holds the data for node `d` at address `d-1`, so one counter running from 0 to `L-1` addresses all banks at the same time.

Writes return to the address they were read from, `PIPE` cycles after the read. The check-node units report a parity-failure flag alongside each check-phase write-back, and the controller ORs these flags together. The last write-back of a check phase lands in the first `PIPE` cycles of the following variable phase, while later phase reads proceed (this requires `1 <= PIPE < L`). At that point the controller decides whether to stop. If no check failed, it stops the frame early. Otherwise decoding continues until the `MAX_ITER`th iteration has finished. Before reporting completion, the controller waits until every outstanding write has drained.

Top module: `ldpc_iter_ctrl`

## Requirements
- R1: While reset is held, and right after it is released, `busy_o`, `rd_en_o`, `wr_en_o` and `done_o` are 0.
- R2: The first cycle after a start accepted in idle begins an initialization phase. This phase lasts `L` cycles with `init_mode_o=1` and `rd_en_o=1`, and `rd_addr_o` runs 0,1,…,`L-1`.
- R3: Each iteration has exactly `2L` read cycles, and the two phases follow each other with no gap. The first `L` cycles have `chk_mode_o=1` and the next `L` have `var_mode_o=1`, and in each phase the address runs 0..`L-1`. At most one mode output is high at a time.
- R4: `wr_en_o` and `wr_addr_o` equal `rd_en_o` and `rd_addr_o` delayed by exactly `PIPE` cycles, including the writes still in flight after the reads stop.
- R5: `chk_fail_i` is sampled only in the `L` write-back cycles of a check phase, which start `PIPE` cycles after that phase's first read. A 1 in any of those cycles, including the very last one, marks that iteration as failed. Values outside those windows have no effect.
- R6: If an iteration's check phase has no failure, reads stop after variable-phase address `PIPE-1` of that iteration. `done_o` then rises `PIPE+1` cycles after the last read, with `converged_o=1` and `iters_used_o` equal to that iteration's number.
- R7: If every iteration fails, the frame runs `MAX_ITER` full iterations. `done_o` rises `PIPE+1` cycles after the final variable read, with `converged_o=0` and `iters_used_o=MAX_ITER`.
- R8: `done_o` is a single-cycle pulse. `busy_o` is high from the first initialization cycle through the `done_o` cycle, and low in the cycle after it.
- R9: A start pulse while `busy_o=1` has no effect on the sequence in progress.
- R10: `iter_o` reads 0 during initialization and n during both phases of iteration n, counting from 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Frame start request, honoured only in idle |
| chk_fail_i | input | 1 | OR of check-node parity failures for the current write-back |
| busy_o | output | 1 | Frame in progress |
| init_mode_o | output | 1 | Initialization phase active on the read side |
| chk_mode_o | output | 1 | Check-node phase active on the read side |
| var_mode_o | output | 1 | Variable-node phase active on the read side |
| rd_en_o | output | 1 | Shared memory read enable |
| rd_addr_o | output | $clog2(L) | Shared memory read address |
| wr_en_o | output | 1 | Shared memory write enable |
| wr_addr_o | output | $clog2(L) | Shared memory write address |
| iter_o | output | $clog2(MAX_ITER+1) | Current iteration number |
| done_o | output | 1 | One-cycle end-of-frame pulse |
| converged_o | output | 1 | All checks satisfied, valid with `done_o` |
| iters_used_o | output | $clog2(MAX_ITER+1) | Iterations performed, valid with `done_o` |

## Verification
Two cases are hard to reach from the ports. The first is a parity failure that arrives only on the final check write-back, which happens while the variable phase is already reading. The second is a frame that converges on exactly the last permitted iteration. Directed frames cover both: one places the single failure at the last node index of an iteration, and another fails iterations 1 to 17 and passes the 18th. Random frames draw a failure pattern and failure position for each iteration. They also toggle `chk_fail_i` outside the check write-back windows and pulse `start_i` during busy cycles, so that both inputs are shown to be ignored there.

// File: rtl/ldpc_seq_pkg.sv
package ldpc_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_INIT  = 3'd1,
    ST_CHECK = 3'd2,
    ST_VAR   = 3'd3,
    ST_DONE  = 3'd4
  } seq_state_t;

  // States that issue a memory read each cycle
  function automatic logic issues_read(input seq_state_t s);
    return (s == ST_INIT) || (s == ST_CHECK) || (s == ST_VAR);
  endfunction

  // Wrapping increment for the shared node address
  function automatic int unsigned wrap_next(input int unsigned v, input int unsigned top);
    return (v == top) ? 0 : v + 1;
  endfunction

endpackage

// File: rtl/ldpc_phase_cnt.sv
module ldpc_phase_cnt #(
  parameter int L  = 16,
  parameter int AW = $clog2(L)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run_i,
  output logic [AW-1:0] cnt_o,
  output logic          last_o
);
  import ldpc_seq_pkg::*;

  localparam logic [AW-1:0] TOP = AW'(L - 1);

  logic [AW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (!run_i) cnt_q <= '0;
    else             cnt_q <= AW'(wrap_next(int'(cnt_q), L - 1));
  end

  assign cnt_o  = cnt_q;
  assign last_o = run_i && (cnt_q == TOP);

  // R3: after the last node index the address restarts at zero
  a_r3_wrap_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
    last_o |=> (cnt_q == '0));

endmodule

// File: rtl/ldpc_wb_delay.sv
module ldpc_wb_delay #(
  parameter int DEPTH = 4,
  parameter int AW    = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          vld_i,
  input  logic          chk_i,
  input  logic [AW-1:0] addr_i,
  output logic          vld_o,
  output logic          chk_o,
  output logic [AW-1:0] addr_o,
  output logic          empty_o
);
  logic [DEPTH-1:0] vld_q;
  logic [DEPTH-1:0] chk_q;
  logic [AW-1:0]    addr_q [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
      chk_q <= '0;
      for (int i = 0; i < DEPTH; i++) addr_q[i] <= '0;
    end else begin
      vld_q[0]  <= vld_i;
      chk_q[0]  <= vld_i & chk_i;
      addr_q[0] <= addr_i;
      for (int i = 1; i < DEPTH; i++) begin
        vld_q[i]  <= vld_q[i-1];
        chk_q[i]  <= chk_q[i-1];
        addr_q[i] <= addr_q[i-1];
      end
    end
  end

  assign vld_o   = vld_q[DEPTH-1];
  assign chk_o   = chk_q[DEPTH-1];
  assign addr_o  = addr_q[DEPTH-1];
  assign empty_o = ~|vld_q;

  // R4: a check-tagged write-back is always a valid write-back
  a_r4_tag_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
    chk_o |-> vld_o);

endmodule

// File: rtl/ldpc_syn_acc.sv
module ldpc_syn_acc (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic sample_i,
  input  logic fail_i,
  output logic fail_now_o
);
  logic acc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     acc_q <= 1'b0;
    else if (clr_i) acc_q <= 1'b0;
    else            acc_q <= acc_q | (sample_i & fail_i);
  end

  // Includes the current write-back so the final one counts too
  assign fail_now_o = acc_q | (sample_i & fail_i);

  // R5: a recorded failure persists until the next check phase begins
  a_r5_sticky_fail: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_q && !clr_i) |=> acc_q);

endmodule

// File: rtl/ldpc_iter_ctrl.sv
module ldpc_iter_ctrl #(
  parameter int L        = 16,
  parameter int PIPE     = 4,
  parameter int MAX_ITER = 18,
  localparam int AW = $clog2(L),
  localparam int IW = $clog2(MAX_ITER + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          chk_fail_i,
  output logic          busy_o,
  output logic          init_mode_o,
  output logic          chk_mode_o,
  output logic          var_mode_o,
  output logic          rd_en_o,
  output logic [AW-1:0] rd_addr_o,
  output logic          wr_en_o,
  output logic [AW-1:0] wr_addr_o,
  output logic [IW-1:0] iter_o,
  output logic          done_o,
  output logic          converged_o,
  output logic [IW-1:0] iters_used_o
);
  import ldpc_seq_pkg::*;

  localparam logic [AW-1:0] ADDR_TOP = AW'(L - 1);
  localparam logic [IW-1:0] ITER_CAP = IW'(MAX_ITER);

  seq_state_t    st_q, st_nxt;
  logic [IW-1:0] iter_q;
  logic          conv_q;
  logic [IW-1:0] used_q;

  logic [AW-1:0] cnt;
  logic          cnt_last;
  logic          wb_vld, wb_chk, pipe_empty;
  logic [AW-1:0] wb_addr;
  logic          fail_now;

  // Named events for the assertions
  logic chk_entry;     // next cycle starts a check phase
  logic chk_last_wr;   // final write-back of a check phase
  logic conv_hit;      // that final write-back found no failure
  logic iter_out;      // final variable read of the last allowed iteration

  assign rd_en_o     = issues_read(st_q);
  assign init_mode_o = (st_q == ST_INIT);
  assign chk_mode_o  = (st_q == ST_CHECK);
  assign var_mode_o  = (st_q == ST_VAR);
  assign busy_o      = (st_q != ST_IDLE);
  assign rd_addr_o   = cnt;

  ldpc_phase_cnt #(.L(L), .AW(AW)) u_cnt (
    .clk(clk), .rst_n(rst_n), .run_i(rd_en_o),
    .cnt_o(cnt), .last_o(cnt_last)
  );

  ldpc_wb_delay #(.DEPTH(PIPE), .AW(AW)) u_wb (
    .clk(clk), .rst_n(rst_n),
    .vld_i(rd_en_o), .chk_i(chk_mode_o), .addr_i(cnt),
    .vld_o(wb_vld), .chk_o(wb_chk), .addr_o(wb_addr), .empty_o(pipe_empty)
  );

  assign chk_entry   = (st_nxt == ST_CHECK) && (st_q != ST_CHECK);
  assign chk_last_wr = wb_chk && (wb_addr == ADDR_TOP);

  ldpc_syn_acc u_acc (
    .clk(clk), .rst_n(rst_n), .clr_i(chk_entry),
    .sample_i(wb_chk), .fail_i(chk_fail_i), .fail_now_o(fail_now)
  );

  assign conv_hit = chk_last_wr && !fail_now;
  assign iter_out = (st_q == ST_VAR) && cnt_last && (iter_q == ITER_CAP);

  always_comb begin
    st_nxt = st_q;
    unique case (st_q)
      ST_IDLE:  if (start_i)  st_nxt = ST_INIT;
      ST_INIT:  if (cnt_last) st_nxt = ST_CHECK;
      ST_CHECK: if (cnt_last) st_nxt = ST_VAR;
      ST_VAR: begin
        if (conv_hit)      st_nxt = ST_DONE;
        else if (iter_out) st_nxt = ST_DONE;
        else if (cnt_last) st_nxt = ST_CHECK;
      end
      ST_DONE:  if (pipe_empty) st_nxt = ST_IDLE;
      default:  st_nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      iter_q <= '0;
      conv_q <= 1'b0;
      used_q <= '0;
    end else begin
      st_q <= st_nxt;
      if (st_q == ST_IDLE && start_i) iter_q <= '0;
      else if (chk_entry)             iter_q <= iter_q + 1'b1;
      if (st_q == ST_VAR && conv_hit) begin
        conv_q <= 1'b1;
        used_q <= iter_q;
      end else if (iter_out) begin
        conv_q <= 1'b0;
        used_q <= ITER_CAP;
      end
    end
  end

  assign wr_en_o      = wb_vld;
  assign wr_addr_o    = wb_addr;
  assign iter_o       = iter_q;
  assign done_o       = (st_q == ST_DONE) && pipe_empty;
  assign converged_o  = conv_q;
  assign iters_used_o = used_q;

  // R3: the read-side modes never overlap
  a_r3_one_mode: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({init_mode_o, chk_mode_o, var_mode_o}));

  // R4: idle means every write has drained
  a_r4_idle_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE) |-> !wr_en_o);

  // R6: the stop decision falls inside a variable phase
  a_r6_decide_in_var: assert property (@(posedge clk) disable iff (!rst_n)
    conv_hit |-> (st_q == ST_VAR));

  // R7: the iteration count never passes its cap
  a_r7_iter_cap: assert property (@(posedge clk) disable iff (!rst_n)
    iter_q <= ITER_CAP);

  // R8: completion lasts one cycle
  a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R9: a busy frame only ends through completion
  a_r9_stay_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !done_o) |=> busy_o);

  // R10: moving from variable to check phase advances the iteration by one
  a_r10_iter_step: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_entry && st_q == ST_VAR) |=> (iter_q == $past(iter_q) + 1'b1));

endmodule

// File: tb/ldpc_iter_ctrl_test.sv
module ldpc_iter_ctrl_test;
  localparam int L  = 8;
  localparam int P  = 3;
  localparam int MX = 18;
  localparam int AW = $clog2(L);
  localparam int IW = $clog2(MX + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0;
  logic chk_fail_i = 1'b0;
  logic busy_o, init_mode_o, chk_mode_o, var_mode_o, rd_en_o, wr_en_o;
  logic done_o, converged_o;
  logic [AW-1:0] rd_addr_o, wr_addr_o;
  logic [IW-1:0] iter_o, iters_used_o;

  always #5 clk = ~clk;

  ldpc_iter_ctrl #(.L(L), .PIPE(P), .MAX_ITER(MX)) uut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .chk_fail_i(chk_fail_i),
    .busy_o(busy_o), .init_mode_o(init_mode_o), .chk_mode_o(chk_mode_o),
    .var_mode_o(var_mode_o), .rd_en_o(rd_en_o), .rd_addr_o(rd_addr_o),
    .wr_en_o(wr_en_o), .wr_addr_o(wr_addr_o), .iter_o(iter_o),
    .done_o(done_o), .converged_o(converged_o), .iters_used_o(iters_used_o)
  );

  int checks = 0;
  int failures = 0;
  bit fail_it [1:MX];
  int pick    [1:MX];
  int stop_n;
  bit conv_e;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Expected read side for cycle c after the start (c=1 is the first init cycle)
  function automatic void exp_rd(input int c, output bit en, output int addr,
                                 output int mode, output int it);
    int k, n, r;
    en = 0; addr = 0; mode = 0; it = 0;
    if (c >= 1 && c <= L) begin
      en = 1; addr = c - 1; mode = 1; it = 0;
      return;
    end
    if (c <= L) return;
    k = c - L - 1;
    n = k / (2 * L) + 1;
    r = k % (2 * L);
    if (n > stop_n) return;
    if (conv_e && n == stop_n && r >= L + P) return;
    en = 1; it = n;
    if (r < L) begin mode = 2; addr = r; end
    else       begin mode = 3; addr = r - L; end
  endfunction

  function automatic int done_cycle();
    int last_rd;
    last_rd = L + (stop_n - 1) * 2 * L + (conv_e ? (L + P) : (2 * L));
    return last_rd + P + 1;
  endfunction

  task automatic run_frame(input bit noisy_start);
    int cd;
    conv_e = 0; stop_n = MX;
    for (int n = 1; n <= MX; n++) begin
      if (!fail_it[n]) begin conv_e = 1; stop_n = n; break; end
    end
    cd = done_cycle();
    @(negedge clk);
    start_i = 1'b1; chk_fail_i = 1'b0;
    for (int c = 1; c <= cd + 1; c++) begin
      bit ren, wen;
      int raddr, rmode, rit, waddr, wmode, wit, mexp, mact;
      @(negedge clk);
      exp_rd(c, ren, raddr, rmode, rit);
      exp_rd(c - P, wen, waddr, wmode, wit);
      check(rd_en_o == ren, "R2/R3/R6 rd_en", int'(rd_en_o), int'(ren));
      if (ren) check(int'(rd_addr_o) == raddr, "R2/R3 rd_addr", int'(rd_addr_o), raddr);
      mexp = (rmode == 1) ? 4 : (rmode == 2) ? 2 : (rmode == 3) ? 1 : 0;
      mact = {29'd0, init_mode_o, chk_mode_o, var_mode_o};
      check(mact == mexp, "R3 modes", mact, mexp);
      check(wr_en_o == wen, "R4 wr_en", int'(wr_en_o), int'(wen));
      if (wen) check(int'(wr_addr_o) == waddr, "R4 wr_addr", int'(wr_addr_o), waddr);
      if (ren) check(int'(iter_o) == rit, "R10 iter", int'(iter_o), rit);
      check(busy_o == (c <= cd), "R8 busy", int'(busy_o), int'(c <= cd));
      check(done_o == (c == cd), "R8 done pulse", int'(done_o), int'(c == cd));
      if (c == cd) begin
        check(converged_o == conv_e, "R5/R6/R7 converged", int'(converged_o), int'(conv_e));
        check(int'(iters_used_o) == stop_n, "R6/R7 iters_used", int'(iters_used_o), stop_n);
      end
      // R9: start pulses only while busy
      start_i = noisy_start && (c <= cd) && ($urandom % 5 == 0);
      // R5: failure flag inside check write-back windows, noise elsewhere
      if (wen && wmode == 2) chk_fail_i = fail_it[wit] && (waddr == pick[wit]);
      else                   chk_fail_i = ($urandom % 3 == 0);
    end
    start_i = 1'b0; chk_fail_i = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'd4711));
    #1;
    check(!busy_o && !rd_en_o && !wr_en_o && !done_o, "R1 during reset",
          {busy_o, rd_en_o, wr_en_o, done_o}, 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy_o && !rd_en_o && !wr_en_o && !done_o, "R1 after reset",
          {busy_o, rd_en_o, wr_en_o, done_o}, 0);

    // Converge on the first iteration
    for (int n = 1; n <= MX; n++) begin fail_it[n] = 0; pick[n] = 0; end
    run_frame(1'b0);
    // Failures at the first and at the last node index, converge at 3
    fail_it[1] = 1; pick[1] = 0;
    fail_it[2] = 1; pick[2] = L - 1;
    run_frame(1'b1);
    // Never converges
    for (int n = 1; n <= MX; n++) begin fail_it[n] = 1; pick[n] = int'($urandom % L); end
    run_frame(1'b1);
    // Converges on exactly the last allowed iteration
    fail_it[MX] = 0;
    run_frame(1'b0);
    // Random frames
    for (int f = 0; f < 6; f++) begin
      for (int n = 1; n <= MX; n++) begin
        fail_it[n] = ($urandom % 5 != 0);
        pick[n] = int'($urandom % L);
      end
      run_frame(1'b1);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule